// File: doc/BRIEF.md
# Descriptor Completion Decision Unit

This block sits beside the sequencer of a descriptor-driven DMA channel and makes the three decisions that follow the completion of every descriptor: whether the channel must stall on the current descriptor, whether an interrupt is raised, and whether the command pointer follows the descriptor's dependent address or steps to the next descriptor in sequence. Each decision is made by comparing the channel's four device-status bits against its own select register. That register packs a mask and a match value, and a 2-bit mode field in the command word decides how the comparison is used.

The sequencer pulses `done_i` when a descriptor finishes, and it presents the command word fields, the select registers, the status bits and the pointers in the same cycle. One clock later the block presents its results. These are an interrupt pulse, a writeback pulse that tells the sequencer to store status and residual count back to the descriptor, a wait level, the next command pointer and the updated branch-taken bit. The wait decision is evaluated first. When it holds, the writeback, the interrupt and the pointer update are all suppressed.

Top module: `desc_cond_unit`

## Requirements
- R1: A select register carries its 4-bit mask in bits 19:16 and its 4-bit match value in bits 3:0, and all its other bits are ignored. The condition is true when (status AND mask) equals (value AND mask), using the four device-status bits.
- R2: A 2-bit mode field is decoded as 00 = never act, 01 = act when the condition is true, 10 = act when the condition is false, 11 = always act. The interrupt, wait and branch decisions each use this decoding, and each decision has its own select register.
- R3: All outputs change only on the clock edge that samples `done_i` high. `irq_o` and `wb_o` are single-cycle pulses. Without `done_i`, `next_ptr_o`, `brtaken_o` and `wait_o` hold their values.
- R4: When the wait decision holds at a completion, `wait_o` goes to 1, `wb_o` and `irq_o` stay 0, `next_ptr_o` takes `cmd_ptr_i` unchanged and `brtaken_o` takes `brtaken_i`.
- R5: When there is no wait and no branch, `next_ptr_o` becomes `cmd_ptr_i` + 16 and `brtaken_o` is cleared.
- R6: When there is no wait and the branch decision holds, `next_ptr_o` becomes `dep_addr_i` and `brtaken_o` is set.
- R7: When there is no wait, `wb_o` pulses and `irq_o` pulses exactly when the interrupt decision holds, independent of the branch outcome.
- R8: While `rst_n` is low at a clock edge, `irq_o`, `wb_o`, `wait_o` and `brtaken_o` clear and `next_ptr_o` becomes 0.
- R9: The step of 16 wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| done_i | input | 1 | Descriptor completion strobe |
| irq_mode_i | input | 2 | Interrupt mode field of the command word |
| wait_mode_i | input | 2 | Wait mode field of the command word |
| br_mode_i | input | 2 | Branch mode field of the command word |
| irq_sel_i | input | 32 | Interrupt select register (mask 19:16, value 3:0) |
| wait_sel_i | input | 32 | Wait select register (mask 19:16, value 3:0) |
| br_sel_i | input | 32 | Branch select register (mask 19:16, value 3:0) |
| dev_stat_i | input | 4 | Channel device-status bits |
| cmd_ptr_i | input | AW | Current command pointer |
| dep_addr_i | input | AW | Descriptor dependent-address field |
| brtaken_i | input | 1 | Current branch-taken status bit |
| irq_o | output | 1 | Interrupt pulse |
| wb_o | output | 1 | Status/residual writeback pulse |
| wait_o | output | 1 | Channel stalled on current descriptor |
| next_ptr_o | output | AW | Next command pointer |
| brtaken_o | output | 1 | Updated branch-taken status bit |

## Verification
On every cycle, the assertions check the following: pulses appear only after a completion; a wait suppresses writeback and interrupt and leaves the pointer unchanged; a step adds exactly 16 and clears branch-taken; a branch loads the dependent address; and the outputs stay still between completions. The following show only in the bench scenarios, where a behavioural model computes the expected result of every completion: the decoding of the four modes, the match of masked status against the packed select fields, the fact that bits outside those fields are ignored, the independence of the three select registers, and pointer wrap at the top of the address space.

// File: rtl/desc_cond_pkg.sv
// Package: shared constants and types for the descriptor completion
// decision unit. Assumes 32-bit select registers with the mask field
// starting at bit 16 and the match value at bit 0.
package desc_cond_pkg;

    localparam int STAT_W   = 4;
    localparam int SEL_W    = 32;
    localparam int MASK_LSB = 16;
    localparam int VAL_LSB  = 0;

    localparam int NUM_DEC  = 3;
    localparam int DEC_IRQ  = 0;
    localparam int DEC_WAIT = 1;
    localparam int DEC_BR   = 2;

    typedef enum logic [1:0] {
        MODE_NEVER    = 2'b00,
        MODE_IF_TRUE  = 2'b01,
        MODE_IF_FALSE = 2'b10,
        MODE_ALWAYS   = 2'b11
    } cond_mode_e;

endpackage

// File: rtl/dcu_cond_eval.sv
// Module: dcu_cond_eval
// Evaluates one decision. It compares masked device status against the
// masked match value that is packed in a select register, then applies the
// 2-bit mode. The module is purely combinational. Assumes that the mask and
// value fields are STAT_W bits wide at MASK_LSB and VAL_LSB.
module dcu_cond_eval
    import desc_cond_pkg::*;
(
    input  logic [1:0]        mode_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic              hit_o
);

    logic [STAT_W-1:0] mask;
    logic [STAT_W-1:0] match_val;
    logic              cond;

    // Extract the packed fields and form the masked comparison.
    always_comb begin
        mask      = sel_i[MASK_LSB +: STAT_W];
        match_val = sel_i[VAL_LSB  +: STAT_W];
        cond      = ((stat_i & mask) == (match_val & mask));
    end

    // Apply the mode to the condition.
    always_comb begin
        case (cond_mode_e'(mode_i))
            MODE_NEVER:    hit_o = 1'b0;
            MODE_IF_TRUE:  hit_o = cond;
            MODE_IF_FALSE: hit_o = !cond;
            MODE_ALWAYS:   hit_o = 1'b1;
            default:       hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dcu_ptr_step.sv
// Module: dcu_ptr_step
// Holds the next command pointer and the branch-taken bit. On a completion
// it keeps the current pointer (wait), loads the dependent address (branch)
// or steps by one descriptor. Assumes done_i is a single-cycle strobe from
// the sequencer.
module dcu_ptr_step #(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic          wait_hit_i,
    input  logic          br_hit_i,
    input  logic [AW-1:0] cmd_ptr_i,
    input  logic [AW-1:0] dep_addr_i,
    input  logic          brtaken_i,
    output logic [AW-1:0] next_ptr_o,
    output logic          brtaken_o
);

    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    logic [AW-1:0] ptr_q;
    logic          bt_q;

    // Update the pointer and branch-taken bit once per completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            bt_q  <= 1'b0;
        end else if (done_i) begin
            if (wait_hit_i) begin
                ptr_q <= cmd_ptr_i;
                bt_q  <= brtaken_i;
            end else if (br_hit_i) begin
                ptr_q <= dep_addr_i;
                bt_q  <= 1'b1;
            end else begin
                ptr_q <= cmd_ptr_i + STEP;
                bt_q  <= 1'b0;
            end
        end
    end

    assign next_ptr_o = ptr_q;
    assign brtaken_o  = bt_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done_i) |-> ($stable(ptr_q) && $stable(bt_q))) else $error("hold"); // R3

    AST_WAIT_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done_i) && $past(wait_hit_i)) |-> (ptr_q == $past(cmd_ptr_i))) else $error("wait ptr"); // R4

    AST_STEP_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done_i) && !$past(wait_hit_i) && !$past(br_hit_i))
        |-> (ptr_q == $past(cmd_ptr_i) + STEP && !bt_q)) else $error("step"); // R5

    AST_BRANCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done_i) && !$past(wait_hit_i) && $past(br_hit_i))
        |-> (ptr_q == $past(dep_addr_i) && bt_q)) else $error("branch"); // R6

endmodule

// File: rtl/desc_cond_unit.sv
// Module: desc_cond_unit (top)
// Makes the three per-descriptor completion decisions: interrupt, wait and
// branch. Each decision is evaluated with its own select register against
// the device-status bits. Wait is checked first and suppresses the
// writeback, the interrupt and the pointer update. All results are
// registered one cycle after done_i.
module desc_cond_unit
    import desc_cond_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [1:0]        irq_mode_i,
    input  logic [1:0]        wait_mode_i,
    input  logic [1:0]        br_mode_i,
    input  logic [SEL_W-1:0]  irq_sel_i,
    input  logic [SEL_W-1:0]  wait_sel_i,
    input  logic [SEL_W-1:0]  br_sel_i,
    input  logic [STAT_W-1:0] dev_stat_i,
    input  logic [AW-1:0]     cmd_ptr_i,
    input  logic [AW-1:0]     dep_addr_i,
    input  logic              brtaken_i,
    output logic              irq_o,
    output logic              wb_o,
    output logic              wait_o,
    output logic [AW-1:0]     next_ptr_o,
    output logic              brtaken_o
);

    logic [1:0]       modes [NUM_DEC];
    logic [SEL_W-1:0] sels  [NUM_DEC];
    logic [NUM_DEC-1:0] hit;

    logic irq_q;
    logic wb_q;
    logic wait_q;

    // Gather the per-decision mode and select inputs into indexed arrays.
    always_comb begin
        modes[DEC_IRQ]  = irq_mode_i;
        modes[DEC_WAIT] = wait_mode_i;
        modes[DEC_BR]   = br_mode_i;
        sels[DEC_IRQ]   = irq_sel_i;
        sels[DEC_WAIT]  = wait_sel_i;
        sels[DEC_BR]    = br_sel_i;
    end

    // One evaluator per decision.
    for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
        dcu_cond_eval u_eval (
            .mode_i (modes[g]),
            .sel_i  (sels[g]),
            .stat_i (dev_stat_i),
            .hit_o  (hit[g])
        );
    end

    // Register the pulses and the wait level on each completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            wb_q   <= 1'b0;
            wait_q <= 1'b0;
        end else begin
            irq_q <= done_i && !hit[DEC_WAIT] && hit[DEC_IRQ];
            wb_q  <= done_i && !hit[DEC_WAIT];
            if (done_i) begin
                wait_q <= hit[DEC_WAIT];
            end
        end
    end

    dcu_ptr_step #(
        .AW         (AW),
        .DESC_BYTES (DESC_BYTES)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done_i),
        .wait_hit_i (hit[DEC_WAIT]),
        .br_hit_i   (hit[DEC_BR]),
        .cmd_ptr_i  (cmd_ptr_i),
        .dep_addr_i (dep_addr_i),
        .brtaken_i  (brtaken_i),
        .next_ptr_o (next_ptr_o),
        .brtaken_o  (brtaken_o)
    );

    assign irq_o  = irq_q;
    assign wb_o   = wb_q;
    assign wait_o = wait_q;

    AST_PULSE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || wb_o) |-> $past(done_i)) else $error("pulse"); // R3

    AST_WAIT_SUPPRESSES: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> (!irq_o && !wb_o)) else $error("wait suppress"); // R4

    AST_IRQ_WITH_WB: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wb_o) else $error("irq wb"); // R7

    AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done_i) |-> $stable(wait_o)) else $error("wait stable"); // R3

endmodule

// File: tb/desc_cond_unit_tb.sv
// Bench for desc_cond_unit: a behavioural reference model predicts the
// outputs after every clock, and they are compared every cycle.
module desc_cond_unit_tb;

    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        done_i;
    logic [1:0]  irq_mode_i, wait_mode_i, br_mode_i;
    logic [31:0] irq_sel_i, wait_sel_i, br_sel_i;
    logic [3:0]  dev_stat_i;
    logic [31:0] cmd_ptr_i, dep_addr_i;
    logic        brtaken_i;
    logic        irq_o, wb_o, wait_o, brtaken_o;
    logic [31:0] next_ptr_o;

    int errors = 0;
    int checks = 0;
    logic finished = 1'b0;

    // expected state
    logic        e_irq, e_wb, e_wait, e_bt;
    logic [31:0] e_ptr;

    always #4 clk = ~clk;   // 125 MHz

    desc_cond_unit #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .done_i(done_i),
        .irq_mode_i(irq_mode_i), .wait_mode_i(wait_mode_i), .br_mode_i(br_mode_i),
        .irq_sel_i(irq_sel_i), .wait_sel_i(wait_sel_i), .br_sel_i(br_sel_i),
        .dev_stat_i(dev_stat_i), .cmd_ptr_i(cmd_ptr_i), .dep_addr_i(dep_addr_i),
        .brtaken_i(brtaken_i), .irq_o(irq_o), .wb_o(wb_o), .wait_o(wait_o),
        .next_ptr_o(next_ptr_o), .brtaken_o(brtaken_o)
    );

    function automatic bit decide(input int mode, input int sel, input int stat);
        int m = (sel >> 16) & 15;
        int v = sel & 15;
        bit c = ((stat & m) == (v & m));
        if (mode == 0) return 1'b0;
        if (mode == 1) return c;
        if (mode == 2) return !c;
        return 1'b1;
    endfunction

    // Predict next outputs from the inputs now driven.
    task automatic predict();
        if (!rst_n) begin
            e_irq = 0; e_wb = 0; e_wait = 0; e_bt = 0; e_ptr = 0;
        end else if (!done_i) begin
            e_irq = 0; e_wb = 0;
        end else if (decide(wait_mode_i, wait_sel_i, dev_stat_i)) begin
            e_wait = 1; e_irq = 0; e_wb = 0; e_ptr = cmd_ptr_i; e_bt = brtaken_i;
        end else begin
            e_wait = 0; e_wb = 1;
            e_irq = decide(irq_mode_i, irq_sel_i, dev_stat_i);
            if (decide(br_mode_i, br_sel_i, dev_stat_i)) begin
                e_ptr = dep_addr_i; e_bt = 1;
            end else begin
                e_ptr = cmd_ptr_i + 32'd16; e_bt = 0;
            end
        end
    endtask

    // Apply inputs at negedge, clock once, compare at next negedge.
    task automatic cycle(input string tag);
        predict();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (irq_o !== e_irq || wb_o !== e_wb || wait_o !== e_wait ||
            brtaken_o !== e_bt || next_ptr_o !== e_ptr) begin
            errors++;
            $display("FAIL %s: got irq=%0b wb=%0b wait=%0b bt=%0b ptr=%h exp irq=%0b wb=%0b wait=%0b bt=%0b ptr=%h",
                     tag, irq_o, wb_o, wait_o, brtaken_o, next_ptr_o,
                     e_irq, e_wb, e_wait, e_bt, e_ptr);
        end
    endtask

    task automatic complete(input string tag, input int im, input int wm, input int bm,
                            input int isel, input int wsel, input int bsel,
                            input int st, input int cp, input int dp, input bit bt);
        done_i = 1; irq_mode_i = 2'(im); wait_mode_i = 2'(wm); br_mode_i = 2'(bm);
        irq_sel_i = isel; wait_sel_i = wsel; br_sel_i = bsel;
        dev_stat_i = 4'(st); cmd_ptr_i = cp; dep_addr_i = dp; brtaken_i = bt;
        cycle(tag);
        done_i = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] lfsr;
        rst_n = 0; done_i = 0; irq_mode_i = 0; wait_mode_i = 0; br_mode_i = 0;
        irq_sel_i = 0; wait_sel_i = 0; br_sel_i = 0; dev_stat_i = 0;
        cmd_ptr_i = 0; dep_addr_i = 0; brtaken_i = 0;
        @(negedge clk);
        cycle("R8 reset");
        cycle("R8 reset");
        rst_n = 1;
        cycle("R3 idle");
        // R5 step, never branch
        complete("R5 step", 0, 0, 0, 0, 0, 0, 4'h3, 32'h1000, 32'h8000, 1);
        cycle("R3 hold after step");
        // R6 always branch, R7 always irq
        complete("R6 branch", 3, 0, 3, 0, 0, 0, 4'h0, 32'h1010, 32'h2000, 0);
        // R1 if-true match on masked bits, ignore other bits
        complete("R1 match", 1, 0, 1, 32'h7FF3_FFF5, 0, 32'h0003_0001, 4'h5, 32'h2000, 32'h3000, 0);
        complete("R1 mismatch", 1, 0, 1, 32'h0003_0002, 0, 32'h0003_0002, 4'h5, 32'h3000, 32'h4000, 1);
        // R2 if-false mode, distinct select registers
        complete("R2 if-false", 2, 0, 2, 32'h000F_0005, 0, 32'h000F_000A, 4'h5, 32'h4000, 32'h5000, 0);
        complete("R2 zero mask", 1, 2, 1, 32'h0000_000F, 32'h0000_0000, 32'h0000_0003, 4'hC, 32'h5000, 32'h6000, 0);
        // R4 wait always: no wb, no irq, ptr held
        complete("R4 wait", 3, 3, 3, 0, 0, 0, 4'h0, 32'h6000, 32'h7000, 1);
        cycle("R4 wait level holds");
        complete("R4 wait if-true", 3, 1, 3, 0, 32'h0008_0008, 0, 4'h8, 32'h6010, 32'h7000, 0);
        complete("R4 wait released", 3, 1, 0, 0, 32'h0008_0008, 0, 4'h0, 32'h6010, 32'h7000, 0);
        // R9 wrap
        complete("R9 wrap", 0, 0, 0, 0, 0, 0, 4'h0, 32'hFFFF_FFF0, 32'h0, 1);
        complete("R9 wrap near top", 0, 0, 2, 0, 0, 32'h0001_0001, 4'h1, 32'hFFFF_FFF8, 32'h0, 0);
        // back-to-back completions, R3 pulses per completion
        complete("R3 b2b a", 3, 0, 0, 0, 0, 0, 4'h0, 32'h100, 32'h0, 0);
        complete("R3 b2b b", 0, 0, 0, 0, 0, 0, 4'h0, 32'h110, 32'h0, 0);
        // pseudo-random sweep
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            done_i = lfsr[0] | lfsr[5];
            irq_mode_i = lfsr[2:1]; wait_mode_i = lfsr[9:8] & {lfsr[10], 1'b1};
            br_mode_i = lfsr[4:3];
            irq_sel_i = {12'h0, lfsr[15:12], 12'h0, lfsr[19:16]};
            wait_sel_i = {12'h0, lfsr[23:20], 12'h0, lfsr[27:24]};
            br_sel_i = {12'h0, lfsr[31:28], 12'h0, lfsr[11:8]};
            dev_stat_i = lfsr[7:4] ^ lfsr[17:14];
            cmd_ptr_i = {lfsr[27:4], 8'h0} ^ {4'h0, lfsr[31:4]};
            dep_addr_i = ~lfsr;
            brtaken_i = lfsr[13];
            cycle("R2 R7 sweep");
        end
        done_i = 0;
        rst_n = 0;
        cycle("R8 reset again");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule